// File: doc/BRIEF.md
# Cartridge Host Register Window

This block places four byte-wide registers on the CPU bus of a game-console cartridge adapter, at the top four addresses below 0x4000. The CPU uses them to pick the cartridge mode and the ROM bank, to exchange bytes with a host over a byte-wide serial link, and to poll link and board status. A CPU write to the link data location is not stored. It is offered to the serial transmitter, and the bus is held in wait until the transmitter takes the byte. A status read samples the receiver and, when a byte is waiting, captures it so that a later data read returns it and acknowledges the receiver.

The block also watches the CPU interrupt-vector fetches. Two control bits move the NMI vector pair and the IRQ vector pair from ROM onto on-board RAM locations that share the window's addresses, so a host-loaded program can install its own handlers. The RAM array, the serial PHY and the bank-switching datapath sit outside; this block hands them the control byte, the bank byte, a one-cycle resync pulse and the routed address.

Top module: `cart_reg_window`

## Requirements
- R1: While reset is held and after release, the control byte is 0x00, the bank byte is 0x08, the stored status byte is 0xB0 and the captured receive byte is 0x00; a status read with the transmitter ready and no receive byte pending therefore returns 0xB1.
- R2: A write to window offset 0 (control), 1 (bank) or 3 (status) stores the whole byte. Reads of offsets 0 and 1 return the stored byte; a read of offset 3 returns stored bits 7..2 with bit 1 and bit 0 taken live as described in R6.
- R3: The cycle after each write to offset 0, 1 or 3, resync_o is high for one cycle; a write to offset 2 never raises it.
- R4: During a write to offset 2, tx_valid_o is high and tx_data_o carries the written byte; the captured receive byte is not changed by it.
- R5: wait_o is high exactly in the cycles in which tx_valid_o is high and tx_ready_i is low.
- R6: A read of offset 3 returns bit 1 = NOT tx_ready_i and bit 0 = NOT rx_valid_i; when rx_valid_i is high the read captures rx_data_i and records it as pending, and bit 0 of the stored status takes the sampled value.
- R7: A read of offset 2 returns the captured receive byte. If a byte is pending, rx_ack_o is high for exactly one cycle, the cycle after the read, and the byte is no longer pending; with nothing pending no ack is given.
- R8: With control bit 2 set, a bus address of 0xFFFA or 0xFFFB raises vec_ram_o and routes vec_addr_o to 0x3FFC or 0x3FFD (bit 0 kept), with rom_sel_o low.
- R9: With control bit 1 set, a bus address of 0xFFFE or 0xFFFF raises vec_ram_o and routes vec_addr_o to 0x3FFE or 0x3FFF (bit 0 kept), with rom_sel_o low.
- R10: When the matching redirect bit is clear, vector addresses and every other address are passed unchanged on vec_addr_o with vec_ram_o low, and rom_sel_o equals address bit 15; control bits 0, 3 and 4 do not affect routing.
- R11: Accesses outside 0x3FFC..0x3FFF leave every register unchanged, and rdata_o is 0x00 whenever no window read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rd_i | input | 1 | CPU read strobe |
| wr_i | input | 1 | CPU write strobe, held while wait_o is high |
| rdata_o | output | 8 | Read data for window reads, else 0 |
| wait_o | output | 1 | Bus stall while a link byte is not accepted |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Transmitter can take a byte |
| rx_valid_i | input | 1 | Receiver holds a byte |
| rx_data_i | input | 8 | Received byte |
| rx_ack_o | output | 1 | Received byte consumed |
| vec_ram_o | output | 1 | Current address is a redirected vector |
| vec_addr_o | output | 16 | Routed address for the memory path |
| rom_sel_o | output | 1 | Access goes to ROM / mapper |
| ctrl_o | output | 8 | Control byte to the bank logic |
| bank_o | output | 8 | Bank byte to the bank logic |
| resync_o | output | 1 | Bank mapping must be refreshed |

## Verification
The bench holds a link write in wait for several cycles before the transmitter becomes ready; a design that dropped or latched the stall would release the bus early or hang it. It reads the data location twice after one capture, so a design that acked every data read, or acked in the same cycle as the read, shows an extra or misplaced ack. It walks each vector address under every combination of the two redirect bits plus the unrelated control bits, catching swapped pairs, a lost address bit 0 or ROM selected alongside RAM. Writes just outside the window check that the decode uses all upper address bits.

// File: rtl/cart_win_pkg.sv
package cart_win_pkg;
  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_BANK = 2'd1;
  localparam logic [1:0] OFF_DATA = 2'd2;
  localparam logic [1:0] OFF_STAT = 2'd3;

  // control bits
  localparam int CB_CART    = 0;
  localparam int CB_IRQ_RAM = 1;
  localparam int CB_NMI_RAM = 2;
  localparam int CB_NMI_OFF = 3;
  localparam int CB_ONEBANK = 4;

  // status bits
  localparam int SB_RX_EMPTY = 0;
  localparam int SB_TX_BUSY  = 1;

  localparam logic [7:0] CTRL_RST = 8'h00;
  localparam logic [7:0] BANK_RST = 8'h08;
  localparam logic [7:0] STAT_RST = 8'hB0;
  localparam logic [7:0] DATA_RST = 8'h00;
endpackage

// File: rtl/cart_win_decode.sv
module cart_win_decode #(
  parameter int          AW       = 16,
  parameter logic [15:0] WIN_BASE = 16'h3FFC,
  parameter logic [15:0] NMI_VEC  = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC  = 16'hFFFE
) (
  input  logic [AW-1:0] addr_i,
  input  logic          nmi_ram_i,
  input  logic          irq_ram_i,
  output logic          win_hit_o,
  output logic [1:0]    off_o,
  output logic          vec_ram_o,
  output logic [AW-1:0] vec_addr_o,
  output logic          rom_sel_o
);
  localparam logic [AW-3:0] WIN_TAG = WIN_BASE[AW-1:2];

  logic [1:0] vec_hit;
  logic [1:0] vec_en;
  assign vec_en = {irq_ram_i, nmi_ram_i};

  // index 0: NMI pair -> window+0/1, index 1: IRQ pair -> window+2/3
  for (genvar v = 0; v < 2; v++) begin : g_vec
    localparam logic [15:0] VEC = (v == 0) ? NMI_VEC : IRQ_VEC;
    assign vec_hit[v] = vec_en[v] && (addr_i[AW-1:1] == VEC[AW-1:1]);
  end

  assign win_hit_o = (addr_i[AW-1:2] == WIN_TAG);
  assign off_o     = addr_i[1:0];
  assign vec_ram_o = |vec_hit;

  always_comb begin
    vec_addr_o = addr_i;
    if (vec_hit[0])      vec_addr_o = {WIN_TAG, 1'b0, addr_i[0]};
    else if (vec_hit[1]) vec_addr_o = {WIN_TAG, 1'b1, addr_i[0]};
  end

  assign rom_sel_o = addr_i[AW-1] && !vec_ram_o;
endmodule

// File: rtl/cart_win_regs.sv
module cart_win_regs
  import cart_win_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    off_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          stat_rd_i,
  input  logic          data_rd_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] bank_o,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] data_o,
  output logic          pend_o,
  output logic          resync_o
);
  logic [DW-1:0] ctrl_q, bank_q, stat_q, data_q;
  logic          pend_q, resync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      bank_q   <= BANK_RST;
      stat_q   <= STAT_RST;
      data_q   <= DATA_RST;
      pend_q   <= 1'b0;
      resync_q <= 1'b0;
    end else begin
      resync_q <= wr_en_i;
      if (wr_en_i) begin
        case (off_i)
          OFF_CTRL: ctrl_q <= wdata_i;
          OFF_BANK: bank_q <= wdata_i;
          OFF_STAT: stat_q <= wdata_i;
          default: ;
        endcase
      end
      if (stat_rd_i) begin
        stat_q[SB_RX_EMPTY] <= ~rx_valid_i;
        if (rx_valid_i) begin
          data_q <= rx_data_i;
          pend_q <= 1'b1;
        end
      end
      if (data_rd_i) pend_q <= 1'b0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign bank_o   = bank_q;
  assign status_o = stat_q;
  assign data_o   = data_q;
  assign pend_o   = pend_q;
  assign resync_o = resync_q;
endmodule

// File: rtl/cart_win_link.sv
module cart_win_link #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_req_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tx_ready_i,
  input  logic          data_rd_i,
  input  logic          pend_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          wait_o,
  output logic          rx_ack_o
);
  logic ack_q;

  assign tx_valid_o = tx_req_i;
  assign tx_data_o  = wdata_i;
  assign wait_o     = tx_req_i && !tx_ready_i;

  // ack only a byte that a status read captured
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= data_rd_i && pend_i;
  end

  assign rx_ack_o = ack_q;
endmodule

// File: rtl/cart_reg_window.sv
module cart_reg_window
  import cart_win_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] WIN_BASE = 16'h3FFC,
  parameter logic [15:0] NMI_VEC  = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC  = 16'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output logic [DW-1:0] rdata_o,
  output logic          wait_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_ack_o,
  output logic          vec_ram_o,
  output logic [AW-1:0] vec_addr_o,
  output logic          rom_sel_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] bank_o,
  output logic          resync_o
);
  logic          win_hit;
  logic [1:0]    off;
  logic [DW-1:0] stat_w, data_w;
  logic          pend_w;
  logic          reg_wr, tx_req, stat_rd, data_rd;

  cart_win_decode #(
    .AW(AW), .WIN_BASE(WIN_BASE), .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_dec (
    .addr_i    (addr_i),
    .nmi_ram_i (ctrl_o[CB_NMI_RAM]),
    .irq_ram_i (ctrl_o[CB_IRQ_RAM]),
    .win_hit_o (win_hit),
    .off_o     (off),
    .vec_ram_o (vec_ram_o),
    .vec_addr_o(vec_addr_o),
    .rom_sel_o (rom_sel_o)
  );

  assign reg_wr  = wr_i && win_hit && (off != OFF_DATA);
  assign tx_req  = wr_i && win_hit && (off == OFF_DATA);
  assign stat_rd = rd_i && win_hit && (off == OFF_STAT);
  assign data_rd = rd_i && win_hit && (off == OFF_DATA);

  cart_win_regs #(.DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_wr),
    .off_i     (off),
    .wdata_i   (wdata_i),
    .stat_rd_i (stat_rd),
    .data_rd_i (data_rd),
    .rx_valid_i(rx_valid_i),
    .rx_data_i (rx_data_i),
    .ctrl_o    (ctrl_o),
    .bank_o    (bank_o),
    .status_o  (stat_w),
    .data_o    (data_w),
    .pend_o    (pend_w),
    .resync_o  (resync_o)
  );

  cart_win_link #(.DW(DW)) u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_req_i  (tx_req),
    .wdata_i   (wdata_i),
    .tx_ready_i(tx_ready_i),
    .data_rd_i (data_rd),
    .pend_i    (pend_w),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o),
    .wait_o    (wait_o),
    .rx_ack_o  (rx_ack_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && win_hit) begin
      case (off)
        OFF_CTRL: rdata_o = ctrl_o;
        OFF_BANK: rdata_o = bank_o;
        OFF_DATA: rdata_o = data_w;
        default: begin
          rdata_o              = stat_w;
          rdata_o[SB_TX_BUSY]  = ~tx_ready_i;
          rdata_o[SB_RX_EMPTY] = ~rx_valid_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/cart_reg_window_chk.sv
module cart_reg_window_chk #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] WIN_BASE = 16'h3FFC,
  parameter logic [15:0] NMI_VEC  = 16'hFFFA
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [DW-1:0] rdata_o,
  input logic          wait_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic          rx_ack_o,
  input logic          vec_ram_o,
  input logic [AW-1:0] vec_addr_o,
  input logic          rom_sel_o,
  input logic          resync_o,
  input logic [DW-1:0] data_w
);
  logic hit;
  assign hit = (addr_i[AW-1:2] == WIN_BASE[AW-1:2]);

  a_r3_resync_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> $past(wr_i && hit && addr_i[1:0] != 2'd2));
  a_r5_wait_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> (tx_valid_o && !tx_ready_i));
  a_r5_wait_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |-> wait_o);
  a_r4_data_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> $stable(data_w));
  a_r7_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ack_o |=> !rx_ack_o);
  a_r7_ack_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ack_o |-> $past(rd_i && hit && addr_i[1:0] == 2'd2));
  a_r8_nmi_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_ram_o && addr_i[AW-1:1] == NMI_VEC[AW-1:1]) |->
      (vec_addr_o == {WIN_BASE[AW-1:2], 1'b0, addr_i[0]}));
  a_r10_rom_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_sel_o |-> !vec_ram_o);
  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && hit) |-> (rdata_o == '0));
endmodule

bind cart_reg_window cart_reg_window_chk #(
  .AW(AW), .DW(DW), .WIN_BASE(WIN_BASE), .NMI_VEC(NMI_VEC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .rdata_o   (rdata_o),
  .wait_o    (wait_o),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .rx_ack_o  (rx_ack_o),
  .vec_ram_o (vec_ram_o),
  .vec_addr_o(vec_addr_o),
  .rom_sel_o (rom_sel_o),
  .resync_o  (resync_o),
  .data_w    (data_w)
);

// File: tb/cart_reg_window_tb.sv
module cart_reg_window_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic        tx_ready = 1'b1, rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [7:0]  rdata, tx_data, ctrl, bank;
  logic        wait_s, tx_valid, rx_ack, vec_ram, rom_sel, resync;
  logic [15:0] vec_addr;

  logic        g_txr = 1'b1, g_rxv = 1'b0;
  logic [7:0]  g_rxd = '0;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";

  // reference state
  logic [7:0] m_ctrl, m_bank, m_stat, m_data;
  logic       m_pend, m_resync, m_ack;

  always #4 clk = ~clk;

  cart_reg_window u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .wait_o(wait_s),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ack_o(rx_ack),
    .vec_ram_o(vec_ram), .vec_addr_o(vec_addr), .rom_sel_o(rom_sel),
    .ctrl_o(ctrl), .bank_o(bank), .resync_o(resync)
  );

  function automatic bit in_win(input logic [15:0] a);
    return a >= 16'h3FFC && a <= 16'h3FFF;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 8'h00; m_bank = 8'h08; m_stat = 8'hB0; m_data = 8'h00;
      m_pend = 0; m_resync = 0; m_ack = 0;
    end else begin
      m_resync = wr && in_win(addr) && addr[1:0] != 2;
      m_ack    = rd && in_win(addr) && addr[1:0] == 2 && m_pend;
      if (wr && in_win(addr)) begin
        if (addr[1:0] == 0) m_ctrl = wdata;
        if (addr[1:0] == 1) m_bank = wdata;
        if (addr[1:0] == 3) m_stat = wdata;
      end
      if (rd && in_win(addr) && addr[1:0] == 3) begin
        m_stat[0] = !rx_valid;
        if (rx_valid) begin m_data = rx_data; m_pend = 1; end
      end
      if (rd && in_win(addr) && addr[1:0] == 2) m_pend = 0;
    end
  end

  task automatic cmp(input string sig, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, sig, act, exp);
    end
  endtask

  task automatic check_all();
    logic [7:0]  e_rd;
    logic        nmi, irq, e_tv;
    logic [15:0] e_va;
    e_rd = 8'h00;
    if (rd && in_win(addr)) begin
      case (addr[1:0])
        2'd0: e_rd = m_ctrl;
        2'd1: e_rd = m_bank;
        2'd2: e_rd = m_data;
        default: e_rd = {m_stat[7:2], !tx_ready, !rx_valid};
      endcase
    end
    e_tv = wr && addr == 16'h3FFE;
    nmi  = m_ctrl[2] && (addr == 16'hFFFA || addr == 16'hFFFB);
    irq  = m_ctrl[1] && (addr == 16'hFFFE || addr == 16'hFFFF);
    e_va = nmi ? (16'h3FFC + addr[0]) : irq ? (16'h3FFE + addr[0]) : addr;
    cmp("rdata", rdata, e_rd);
    cmp("tx_valid", tx_valid, e_tv);
    if (e_tv) cmp("tx_data", tx_data, wdata);
    cmp("wait", wait_s, e_tv && !tx_ready);
    cmp("rx_ack", rx_ack, m_ack);
    cmp("resync", resync, m_resync);
    cmp("vec_ram", vec_ram, nmi || irq);
    cmp("vec_addr", vec_addr, e_va);
    cmp("rom_sel", rom_sel, addr[15] && !(nmi || irq));
    cmp("ctrl", ctrl, m_ctrl);
    cmp("bank", bank, m_bank);
  endtask

  task automatic cyc(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d;
    tx_ready = g_txr; rx_valid = g_rxv; rx_data = g_rxd;
    #1 check_all();
  endtask

  task automatic idle(); cyc(16'h0000, 0, 0, 8'h00); endtask
  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d); cyc(a, 1, 0, d); endtask
  task automatic rd_reg(input logic [15:0] a); cyc(a, 0, 1, 8'h00); endtask

  task automatic walk_vectors();
    rd_reg(16'hFFFA); rd_reg(16'hFFFB); rd_reg(16'hFFFE); rd_reg(16'hFFFF);
    rd_reg(16'hFFFC); rd_reg(16'h8000); rd_reg(16'h1234);
  endtask

  initial begin
    #150000;
    bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset values
    cur_req = "R1";
    repeat (2) @(negedge clk);
    cmp("ctrl_in_reset", ctrl, 8'h00);
    cmp("bank_in_reset", bank, 8'h08);
    rst_ni = 1'b1;
    idle();
    rd_reg(16'h3FFC); rd_reg(16'h3FFD); rd_reg(16'h3FFE);
    rd_reg(16'h3FFF);
    cmp("status_reset_read", rdata, 8'hB1);

    // R2 / R3: stores and resync
    cur_req = "R2";
    wr_reg(16'h3FFC, 8'h18); wr_reg(16'h3FFD, 8'h1F); wr_reg(16'h3FFF, 8'h5C);
    cur_req = "R3";
    idle(); idle();
    cur_req = "R2";
    rd_reg(16'h3FFC); rd_reg(16'h3FFD); rd_reg(16'h3FFF);

    // R4 / R5: link write with stall
    cur_req = "R4";
    g_txr = 1'b0;
    wr_reg(16'h3FFE, 8'hA5);
    cur_req = "R5";
    wr_reg(16'h3FFE, 8'hA5); wr_reg(16'h3FFE, 8'hA5);
    g_txr = 1'b1;
    wr_reg(16'h3FFE, 8'hA5);
    cur_req = "R3";
    idle();
    cur_req = "R4";
    rd_reg(16'h3FFE);
    cmp("data_after_tx", rdata, 8'h00);
    wr_reg(16'h3FFE, 8'h3C);

    // R6: status sampling
    cur_req = "R6";
    g_txr = 1'b0;
    rd_reg(16'h3FFF);
    g_txr = 1'b1;
    g_rxv = 1'b1; g_rxd = 8'h96;
    rd_reg(16'h3FFF);
    idle();

    // R7: data read and ack
    cur_req = "R7";
    rd_reg(16'h3FFE);
    g_rxv = 1'b0;
    idle();
    rd_reg(16'h3FFE);
    idle(); idle();
    g_rxv = 1'b1; g_rxd = 8'h41;
    rd_reg(16'h3FFF);
    g_rxv = 1'b0;
    rd_reg(16'h3FFE);
    cmp("second_capture", rdata, 8'h41);
    rd_reg(16'h3FFE);
    idle();

    // R8..R10: vector routing under each control setting
    cur_req = "R10";
    wr_reg(16'h3FFC, 8'h00); walk_vectors();
    cur_req = "R8";
    wr_reg(16'h3FFC, 8'h04); walk_vectors();
    cur_req = "R9";
    wr_reg(16'h3FFC, 8'h02); walk_vectors();
    wr_reg(16'h3FFC, 8'h06); walk_vectors();
    cur_req = "R10";
    wr_reg(16'h3FFC, 8'h19); walk_vectors();
    wr_reg(16'hFFFA, 8'h77); wr_reg(16'hFFFE, 8'h77);

    // R11: outside window
    cur_req = "R11";
    wr_reg(16'h3FF8, 8'hEE); wr_reg(16'h3FF9, 8'hEE); wr_reg(16'h7FFC, 8'hEE);
    wr_reg(16'h3FFB, 8'hEE); wr_reg(16'hBFFD, 8'hEE);
    rd_reg(16'h3FFB); rd_reg(16'h7FFF);
    rd_reg(16'h3FFC); rd_reg(16'h3FFD);
    cmp("ctrl_kept", ctrl, 8'h19);
    cmp("bank_kept", bank, 8'h1F);
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule